// File: doc/BRIEF.md
# Prescaled Countdown Timer with Watchdog Mode

This block is a register-mapped countdown timer. Software programs a 32-bit count register that holds a clock divider in its upper half and a tick count in its lower half. Software then enables counting through a mode register. The timer counts bus clocks and flags an expiry once the programmed number of divided ticks has passed. It can stop after one expiry or reload and repeat. The interrupt line follows the pending event flags, but only while the interrupt enable bit is set.

When the watchdog bit is set, an expiry raises a reset request pulse. Supervising software keeps that pulse from happening by writing a fixed keep-alive byte into the top byte of the mode register, which restarts the countdown from the full programmed length. Starting in watchdog mode always clears the interrupt enable, so a watchdog timeout reaches the system only through the reset request.

Top module: `prescaled_timer_wd`

## Requirements
- R1: After reset, the mode, count and status registers read as zero, and irq_o and wdog_rst_o are low.
- R2: The count register (address 1) holds the divider in bits 31:16 and the tick count in bits 15:0. After counting starts, expiry happens exactly divider × ticks clock cycles later. A divider or tick value of 0 counts as 65536.
- R3: Mode register (address 0) bit 12 enables counting. Writing it from 0 to 1 restarts the countdown at full length. While it is 0, no expiry occurs.
- R4: Mode bit 10 selects continuous operation, in which expiries repeat every period. With bit 10 clear, the timer expires once and clears bit 12 by itself.
- R5: Each expiry sets status (address 2) bit 0. Writing ones to status bits 3:0 with byte enable 0 clears them. An expiry in the same cycle as a clear leaves bit 0 set.
- R6: irq_o is high exactly when mode bit 8 is set and any status flag is set.
- R7: Any mode write with byte enable 1 and bit 15 set stores bit 8 as 0, so mode reads back with bit 8 clear.
- R8: A write to address 0 with byte enable 3 and bits 31:24 equal to 0xA5 restarts the countdown at full length. Any other value in that byte is ignored and changes nothing.
- R9: In watchdog mode (mode bit 15), each expiry drives wdog_rst_o high for exactly 4 clock cycles, starting at the expiry edge.
- R10: A count register write reloads both counters at that write's clock edge, so with counting enabled, expiry follows divider × ticks cycles after the write.
- R11: Only the bytes whose byte enable is set are changed by a count register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; counting runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Word address: 0 mode, 1 count, 2 status |
| wr_en_i | input | 1 | Write strobe for one cycle |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt: enabled pending flags |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The properties assume that wr_en_i, addr_i, be_i and wdata_i are known and are sampled once per clock edge. They also assume that a one-shot expiry is not raced by a mode write that touches byte 1 in the same cycle. The stimulus changes inputs only on falling edges and holds each write for exactly one rising edge. It measures expiry by polling the status register between edges. Random dividers and tick counts stay small enough that every countdown completes well inside the run. A single directed case uses the divider value 0 to cover the 65536 wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [1:0] ADDR_MODE  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;

    // mode register bit positions (software visible)
    localparam int MB_IEN  = 8;
    localparam int MB_CONT = 10;
    localparam int MB_EN   = 12;
    localparam int MB_WD   = 15;
    localparam int MODE_BYTE = 1;

    localparam logic [7:0] KEEPALIVE_CODE = 8'hA5;

    typedef struct packed {
        logic wd;
        logic en;
        logic cont;
        logic ien;
    } mode_t;
endpackage

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
    parameter int PRESC_W = 16,
    parameter int PER_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               load_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic [PER_W-1:0]   period_i,
    output logic               expire_o
);
    typedef struct packed {
        logic [PRESC_W-1:0] pc;
        logic [PER_W-1:0]   qc;
    } cnt_t;

    cnt_t st_d, st_q;
    logic pc_zero, qc_zero;

    assign pc_zero  = (st_q.pc == '0);
    assign qc_zero  = (st_q.qc == '0);
    assign expire_o = run_i && !load_i && pc_zero && qc_zero;

    // Counters hold value-1; a field of 0 wraps to all ones, i.e. 2**W steps.
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pc = presc_i - 1'b1;
            st_d.qc = period_i - 1'b1;
        end else if (run_i) begin
            if (pc_zero) begin
                st_d.pc = presc_i - 1'b1;
                if (qc_zero) st_d.qc = period_i - 1'b1;
                else         st_d.qc = st_q.qc - 1'b1;
            end else begin
                st_d.pc = st_q.pc - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> ($stable(st_q.pc) && $stable(st_q.qc)));

    // R10
    load_no_early_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!expire_o || ($past(presc_i) == PRESC_W'(1) && $past(period_i) == PER_W'(1))));
endmodule

// File: rtl/tmr_pulse.sv
module tmr_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic req_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_i)             cnt_d = CW'(LEN);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign req_o = (cnt_q != '0);

    // R9
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> req_o);

    // R9
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> !$past(trig_i));
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int PER_W   = 16,
    parameter int STAT_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 addr_i,
    input  logic                       wr_en_i,
    input  logic [(PRESC_W+PER_W)/8-1:0] be_i,
    input  logic [PRESC_W+PER_W-1:0]   wdata_i,
    input  logic                       expire_i,
    output logic [PRESC_W+PER_W-1:0]   rdata_o,
    output mode_t                      mode_o,
    output logic [PRESC_W-1:0]         presc_nx_o,
    output logic [PER_W-1:0]           period_nx_o,
    output logic                       load_o,
    output logic                       irq_o
);
    localparam int REG_W = PRESC_W + PER_W;
    localparam int NB    = REG_W / 8;

    typedef struct packed {
        mode_t              mode;
        logic [REG_W-1:0]   count;
        logic [STAT_W-1:0]  stat;
    } regs_t;

    regs_t st_d, st_q;

    logic mode_wr, count_wr, stat_wr, mode_byte_wr, ka_hit, start_hit;
    logic [REG_W-1:0] count_nx;

    assign mode_wr      = wr_en_i && (addr_i == ADDR_MODE);
    assign count_wr     = wr_en_i && (addr_i == ADDR_COUNT);
    assign stat_wr      = wr_en_i && (addr_i == ADDR_STAT);
    assign mode_byte_wr = mode_wr && be_i[MODE_BYTE];
    assign ka_hit       = mode_wr && be_i[NB-1] && (wdata_i[REG_W-1 -: 8] == KEEPALIVE_CODE);
    assign start_hit    = mode_byte_wr && wdata_i[MB_EN] && !st_q.mode.en;
    assign load_o       = count_wr || ka_hit || start_hit;

    // byte-lane merge for the count register
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign count_nx[b*8 +: 8] = (count_wr && be_i[b]) ? wdata_i[b*8 +: 8]
                                                          : st_q.count[b*8 +: 8];
    end

    assign presc_nx_o  = count_nx[REG_W-1 -: PRESC_W];
    assign period_nx_o = count_nx[PER_W-1:0];

    always_comb begin
        st_d       = st_q;
        st_d.count = count_nx;
        if (stat_wr && be_i[0])
            st_d.stat = st_q.stat & ~wdata_i[STAT_W-1:0];
        if (expire_i) begin
            st_d.stat[0] = 1'b1;
            if (!st_q.mode.cont) st_d.mode.en = 1'b0;
        end
        if (mode_byte_wr) begin
            st_d.mode.wd   = wdata_i[MB_WD];
            st_d.mode.en   = wdata_i[MB_EN];
            st_d.mode.cont = wdata_i[MB_CONT];
            st_d.mode.ien  = wdata_i[MB_IEN] && !wdata_i[MB_WD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_MODE: begin
                rdata_o[MB_WD]   = st_q.mode.wd;
                rdata_o[MB_EN]   = st_q.mode.en;
                rdata_o[MB_CONT] = st_q.mode.cont;
                rdata_o[MB_IEN]  = st_q.mode.ien;
            end
            ADDR_COUNT: rdata_o = st_q.count;
            ADDR_STAT:  rdata_o[STAT_W-1:0] = st_q.stat;
            default:    rdata_o = '0;
        endcase
    end

    assign mode_o = st_q.mode;
    assign irq_o  = st_q.mode.ien && (|st_q.stat);

    // R7
    wd_blocks_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode.wd |-> !st_q.mode.ien);

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !st_q.mode.cont && !mode_byte_wr) |=> !st_q.mode.en);

    // R5
    expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> st_q.stat[0]);
endmodule

// File: rtl/prescaled_timer_wd.sv
module prescaled_timer_wd
    import tmr_pkg::*;
#(
    parameter int PRESC_W    = 16,
    parameter int PER_W      = 16,
    parameter int STAT_W     = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr_i,
    input  logic        wr_en_i,
    input  logic [3:0]  be_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        irq_o,
    output logic        wdog_rst_o
);
    mode_t              mode;
    logic [PRESC_W-1:0] presc_nx;
    logic [PER_W-1:0]   period_nx;
    logic               load, expire;

    tmr_regfile #(.PRESC_W(PRESC_W), .PER_W(PER_W), .STAT_W(STAT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .be_i       (be_i),
        .wdata_i    (wdata_i),
        .expire_i   (expire),
        .rdata_o    (rdata_o),
        .mode_o     (mode),
        .presc_nx_o (presc_nx),
        .period_nx_o(period_nx),
        .load_o     (load),
        .irq_o      (irq_o)
    );

    tmr_countdown #(.PRESC_W(PRESC_W), .PER_W(PER_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (mode.en),
        .load_i  (load),
        .presc_i (presc_nx),
        .period_i(period_nx),
        .expire_o(expire)
    );

    tmr_pulse #(.LEN(RST_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig_i(expire && mode.wd),
        .req_o (wdog_rst_o)
    );

    // R6
    wd_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.wd |-> !irq_o);

    // R3
    no_expiry_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.en |-> !expire);
endmodule

// File: tb/prescaled_timer_wd_test.sv
`timescale 1ns/1ps
module prescaled_timer_wd_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wrst;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    prescaled_timer_wd uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .be_i(be),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdog_rst_o(wrst)
    );

    function automatic int exp_cycles(input logic [15:0] p, input logic [15:0] t);
        int pe = (p == 0) ? 65536 : int'(p);
        int te = (t == 0) ? 65536 : int'(t);
        return pe * te;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called between edges; leaves just after the next falling edge
    task automatic wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
        addr = a; be = b; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; be = '0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic poll(input int limit, output int cnt);
        cnt = 0;
        addr = 2'd2;
        do begin
            @(posedge clk);
            @(negedge clk);
            #1;
            cnt++;
        end while (!rdata[0] && cnt < limit);
    endtask

    initial begin
        #(20.0 * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset values
        rd(2'd0, d); chk("R1 mode", d, 32'h0);
        rd(2'd1, d); chk("R1 count", d, 32'h0);
        rd(2'd2, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 wdog_rst", {31'b0, wrst}, 32'h0);

        // R11 byte enables on count
        wr(2'd1, 4'b1111, 32'h0003_0005);
        wr(2'd1, 4'b0100, 32'hAAFF_BBCC);
        rd(2'd1, d); chk("R11 partial write", d, 32'h00FF_0005);

        // R2 / R4 one-shot
        wr(2'd1, 4'b1111, 32'h0003_0004);
        wr(2'd0, 4'b1111, 32'h0000_1000);
        poll(200, n); chk("R2 one-shot cycles", n, exp_cycles(16'd3, 16'd4));
        rd(2'd0, d); chk("R4 enable cleared", d, 32'h0);
        rd(2'd2, d); chk("R5 status set", d, 32'h1);
        chk("R6 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd2, 4'b0001, 32'h0000_000F);
        rd(2'd2, d); chk("R5 w1c", d, 32'h0);

        // R4 / R6 continuous with interrupt
        wr(2'd1, 4'b1111, 32'h0002_0003);
        wr(2'd0, 4'b1111, 32'h0000_1500);
        poll(200, n); chk("R4 continuous first", n, 6);
        chk("R6 irq high", {31'b0, irq}, 32'h1);
        wr(2'd2, 4'b0001, 32'h0000_0001);
        chk("R6 irq low after clear", {31'b0, irq}, 32'h0);
        poll(200, n); chk("R4 continuous repeat", n, 5);
        rd(2'd0, d); chk("R4 still enabled", d, 32'h0000_1500);
        wr(2'd0, 4'b1111, 32'h0);
        wr(2'd2, 4'b0001, 32'h1);

        // R3 stop and restart
        wr(2'd1, 4'b1111, 32'h0001_000A);
        wr(2'd0, 4'b1111, 32'h0000_1000);
        repeat (4) @(negedge clk);
        wr(2'd0, 4'b0010, 32'h0);
        repeat (20) @(negedge clk);
        rd(2'd2, d); chk("R3 no expiry while off", d, 32'h0);
        wr(2'd0, 4'b0010, 32'h0000_1000);
        poll(200, n); chk("R3 restart full period", n, 10);
        wr(2'd2, 4'b0001, 32'h1);

        // R10 count rewrite while running
        wr(2'd1, 4'b1111, 32'h0001_0032);
        wr(2'd0, 4'b1111, 32'h0000_1000);
        repeat (10) @(negedge clk);
        wr(2'd1, 4'b1111, 32'h0001_0007);
        poll(200, n); chk("R10 reload on write", n, 7);
        wr(2'd2, 4'b0001, 32'h1);

        // R7 / R8 / R9 watchdog
        wr(2'd1, 4'b1111, 32'h0001_0014);
        wr(2'd0, 4'b1111, 32'h0000_9100);
        rd(2'd0, d); chk("R7 ien cleared in watchdog", d, 32'h0000_9000);
        for (int k = 0; k < 5; k++) begin
            repeat (10) @(negedge clk);
            wr(2'd0, 4'b1000, 32'hA500_0000);
        end
        rd(2'd2, d); chk("R8 keep-alive prevents expiry", d, 32'h0);
        chk("R8 no reset request", {31'b0, wrst}, 32'h0);
        wr(2'd0, 4'b1000, 32'h5A00_0000);
        rd(2'd0, d); chk("R8 wrong byte ignored", d, 32'h0000_9000);
        poll(200, n); chk("R8 countdown from last keep-alive", n, 19);
        chk("R9 reset cycle 1", {31'b0, wrst}, 32'h1);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk); #1;
            chk("R9 reset held", {31'b0, wrst}, 32'h1);
        end
        @(negedge clk); #1;
        chk("R9 reset released", {31'b0, wrst}, 32'h0);
        chk("R6 no irq in watchdog", {31'b0, irq}, 32'h0);
        rd(2'd0, d); chk("R4 watchdog one-shot stopped", d, 32'h0000_8000);
        wr(2'd0, 4'b1111, 32'h0);
        wr(2'd2, 4'b0001, 32'hF);

        // R2 divider zero means 65536
        wr(2'd1, 4'b1111, 32'h0000_0001);
        wr(2'd0, 4'b1111, 32'h0000_1000);
        poll(70000, n); chk("R2 divider zero", n, 65536);
        wr(2'd2, 4'b0001, 32'h1);

        // R2 / R6 random one-shot runs
        for (int i = 0; i < 20; i++) begin
            logic [15:0] p, t;
            logic ie;
            p = 16'($urandom_range(1, 6));
            t = 16'($urandom_range(1, 12));
            ie = 1'($urandom_range(0, 1));
            wr(2'd1, 4'b1111, {p, t});
            wr(2'd0, 4'b1111, ie ? 32'h0000_1100 : 32'h0000_1000);
            poll(200, n); chk("R2 random cycles", n, exp_cycles(p, t));
            chk("R6 random irq", {31'b0, irq}, {31'b0, ie});
            rd(2'd0, d); chk("R4 random stop", d, ie ? 32'h0000_0100 : 32'h0);
            wr(2'd2, 4'b0001, 32'h1);
            chk("R5 random clear irq", {31'b0, irq}, 32'h0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule